// File: doc/BRIEF.md
# Dual Instruction Prefetch Buffer

This block sits between an instruction cache and a variable-length instruction decoder. It holds two 16-byte lines of instruction bytes. It fetches aligned lines from memory in address order, on its own, so that the decoder seldom finds the buffer empty. The decoder sees a window of the next three bytes at the read pointer, together with a count of how many of those bytes are valid. Once it has sized an instruction, the decoder returns a consume count that moves the pointer forward.

When every byte of the older line has been consumed, that line slot is released, and the fetch side asks for the next sequential line on the following cycle. A taken branch pulses the flush input with a new byte address. The flush empties both slots, moves the read pointer to the target and restarts fetching at the line that contains the target. Each request carries an epoch tag. A response whose tag belongs to an epoch before the latest flush is thrown away.

Top module: `pfb_prefetch_buf`

## Requirements
- R1: After reset the window count is 0, and the block requests the line at the reset address (address 0) with epoch tag 0.
- R2: A request is made only when no request is outstanding and a line slot is free. Each request address is a 16-byte aligned line address. Successive requests cover consecutive lines, and each carries the current epoch tag.
- R3: Window byte k, on bits [8k+7:8k], is the instruction byte at address pointer+k. The window count is the smaller of 3 and the number of buffered bytes from the pointer onward.
- R4: When both lines are valid and the pointer is within two bytes of the end of the older line, the window continues into the newer line.
- R5: A consume count c with 1 <= c <= the buffered byte count is accepted and advances the pointer by c.
- R6: A consume count of 0, or one larger than the buffered byte count, is ignored. The window and the pointer stay unchanged.
- R7: The cycle after a consume that finishes the older line, a request for the next sequential line is raised, provided no request is outstanding.
- R8: A flush empties both lines, so the window count is 0 on the next cycle. It advances the epoch tag by one, modulo 4, and the next request goes to the line that contains the flush address.
- R9: After a flush to an unaligned address, bytes of the first line below the target offset are never presented. The first window byte is the byte at the flush address.
- R10: A response whose epoch tag differs from the current epoch is dropped and fills no line.
- R11: While both lines are valid, no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Branch redirect pulse |
| flush_addr_i | input | 32 | Byte address of the redirect target |
| cons_valid_i | input | 1 | Decoder presents a consume count |
| cons_cnt_i | input | 4 | Number of bytes consumed (1 to 15) |
| win_bytes_o | output | 24 | Three-byte decode window, lowest address in bits [7:0] |
| win_cnt_o | output | 2 | Number of valid window bytes (0 to 3) |
| mem_req_o | output | 1 | Line request valid |
| mem_req_addr_o | output | 32 | Aligned line address of the request |
| mem_req_epoch_o | output | 2 | Epoch tag sent with the request |
| mem_gnt_i | input | 1 | Memory accepts the request this cycle |
| mem_rsp_valid_i | input | 1 | Line response valid |
| mem_rsp_epoch_i | input | 2 | Epoch tag returned with the response |
| mem_rsp_data_i | input | 128 | Line data, byte i on bits [8i+7:8i] |

## Verification
Several rules are checked by assertions on every cycle:
- No fill ever lands on a valid slot.
- Only a valid line is ever released.
- No request is made while both slots are full.
- Requests are aligned, and there is at most one in flight.
- The window is empty after a flush and never reports more bytes than are buffered.
- The pointer moves by exactly the accepted count and holds when a consume is ignored.

Byte contents need the bench's reference model, which compares the window against the memory image and the request stream against the expected line order on every clock. That covers straddling windows, unaligned flush targets, refill after a line is used up, and stale responses that arrive after a redirect.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 16;
    localparam int NUM_LINES  = 2;
    localparam int WIN_BYTES  = 3;
    localparam int CNT_W      = 4;
    localparam int EPOCH_W    = 2;

    localparam int OFF_W     = $clog2(LINE_BYTES);
    localparam int LINE_BITS = LINE_BYTES * 8;
    localparam int WIN_BITS  = WIN_BYTES * 8;
    localparam int AVAIL_W   = OFF_W + $clog2(NUM_LINES) + 1;
    localparam int WCNT_W    = $clog2(WIN_BYTES + 1);
    localparam int SLOT_W    = $clog2(NUM_LINES);

    typedef logic [ADDR_W-1:0]    addr_t;
    typedef logic [LINE_BITS-1:0] line_t;
    typedef logic [EPOCH_W-1:0]   epoch_t;
    typedef logic [OFF_W-1:0]     off_t;
    typedef logic [SLOT_W-1:0]    slot_t;
    typedef logic [AVAIL_W-1:0]   avail_t;

    // Write of one returned line into a slot
    typedef struct packed {
        logic  vld;
        slot_t slot;
        line_t data;
    } fill_t;

    function automatic addr_t line_base(addr_t a);
        return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    endfunction

    function automatic logic [7:0] line_byte(line_t d, off_t i);
        return d[i*8 +: 8];
    endfunction

endpackage

// File: rtl/pfb_line_store.sv
module pfb_line_store
    import pfb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush_i,
    input  fill_t                   fill_i,
    input  logic                    drop_i,
    input  slot_t                   drop_slot_i,
    output logic [NUM_LINES-1:0]    vld_o,
    output line_t [NUM_LINES-1:0]   data_o
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_slot
        logic  vld_q;
        line_t data_q;

        always_ff @(posedge clk) begin
            if (rst || flush_i) begin
                vld_q <= 1'b0;
            end else if (fill_i.vld && fill_i.slot == SLOT_W'(g)) begin
                vld_q <= 1'b1;
            end else if (drop_i && drop_slot_i == SLOT_W'(g)) begin
                vld_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_i.vld && fill_i.slot == SLOT_W'(g)) begin
                data_q <= fill_i.data;
            end
        end

        assign vld_o[g]  = vld_q;
        assign data_o[g] = data_q;
    end

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        fill_i.vld |-> !vld_o[fill_i.slot]); // R2

    AST_DROP_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
        drop_i |-> vld_o[drop_slot_i]); // R7

endmodule

// File: rtl/pfb_fetch_ctl.sv
module pfb_fetch_ctl
    import pfb_pkg::*;
#(
    parameter addr_t RESET_ADDR = '0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   flush_i,
    input  addr_t  flush_addr_i,
    input  logic   slot_free_i,
    input  slot_t  tgt_slot_i,
    output logic   mem_req_o,
    output addr_t  mem_req_addr_o,
    output epoch_t mem_req_epoch_o,
    input  logic   mem_gnt_i,
    input  logic   mem_rsp_valid_i,
    input  epoch_t mem_rsp_epoch_i,
    input  line_t  mem_rsp_data_i,
    output fill_t  fill_o
);

    logic   pend_q;
    epoch_t epoch_q;
    addr_t  next_q;
    slot_t  slot_q;
    logic   fire;
    logic   rsp_match;

    assign mem_req_o       = !pend_q && slot_free_i;
    assign mem_req_addr_o  = next_q;
    assign mem_req_epoch_o = epoch_q;
    assign fire            = mem_req_o && mem_gnt_i;
    assign rsp_match       = mem_rsp_valid_i && pend_q && (mem_rsp_epoch_i == epoch_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            epoch_q <= '0;
            next_q  <= line_base(RESET_ADDR);
            slot_q  <= '0;
        end else if (flush_i) begin
            pend_q  <= 1'b0;
            epoch_q <= epoch_q + 1'b1;
            next_q  <= line_base(flush_addr_i);
        end else begin
            if (fire) begin
                pend_q <= 1'b1;
                next_q <= next_q + ADDR_W'(LINE_BYTES);
                slot_q <= tgt_slot_i;
            end else if (rsp_match) begin
                pend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        fill_o.vld  = rsp_match && !flush_i;
        fill_o.slot = slot_q;
        fill_o.data = mem_rsp_data_i;
    end

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> (mem_req_addr_o[OFF_W-1:0] == '0)); // R2

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        (fire && !flush_i) |=> !mem_req_o); // R2

    AST_FLUSH_EPOCH: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (mem_req_epoch_o == $past(mem_req_epoch_o) + 1'b1)); // R8

endmodule

// File: rtl/pfb_window.sv
module pfb_window
    import pfb_pkg::*;
(
    input  logic [NUM_LINES-1:0]  vld_i,
    input  line_t [NUM_LINES-1:0] data_i,
    input  slot_t                 hd_i,
    input  off_t                  off_i,
    output avail_t                avail_o,
    output logic [WIN_BITS-1:0]   win_bytes_o,
    output logic [WCNT_W-1:0]     win_cnt_o
);

    slot_t nx;
    assign nx = hd_i + 1'b1;

    always_comb begin
        if (!vld_i[hd_i]) begin
            avail_o = '0;
        end else begin
            avail_o = avail_t'(LINE_BYTES) - avail_t'(off_i);
            if (vld_i[nx]) begin
                avail_o = avail_o + avail_t'(LINE_BYTES);
            end
        end
        if (avail_o >= avail_t'(WIN_BYTES)) begin
            win_cnt_o = WCNT_W'(WIN_BYTES);
        end else begin
            win_cnt_o = WCNT_W'(avail_o);
        end
    end

    for (genvar k = 0; k < WIN_BYTES; k++) begin : g_byte
        logic [OFF_W:0] pos;
        logic [7:0]     b;
        assign pos = {1'b0, off_i} + (OFF_W+1)'(k);
        always_comb begin
            if (pos[OFF_W]) begin
                b = line_byte(data_i[nx], pos[OFF_W-1:0]);
            end else begin
                b = line_byte(data_i[hd_i], pos[OFF_W-1:0]);
            end
            win_bytes_o[k*8 +: 8] = (WCNT_W'(k) < win_cnt_o) ? b : 8'h00;
        end
    end

endmodule

// File: rtl/pfb_prefetch_buf.sv
module pfb_prefetch_buf
    import pfb_pkg::*;
#(
    parameter addr_t RESET_ADDR = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush_i,
    input  logic [ADDR_W-1:0]    flush_addr_i,
    input  logic                 cons_valid_i,
    input  logic [CNT_W-1:0]     cons_cnt_i,
    output logic [WIN_BITS-1:0]  win_bytes_o,
    output logic [WCNT_W-1:0]    win_cnt_o,
    output logic                 mem_req_o,
    output logic [ADDR_W-1:0]    mem_req_addr_o,
    output logic [EPOCH_W-1:0]   mem_req_epoch_o,
    input  logic                 mem_gnt_i,
    input  logic                 mem_rsp_valid_i,
    input  logic [EPOCH_W-1:0]   mem_rsp_epoch_i,
    input  logic [LINE_BITS-1:0] mem_rsp_data_i
);

    addr_t                 rd_ptr_q;
    slot_t                 hd_q;
    logic [NUM_LINES-1:0]  vld;
    line_t [NUM_LINES-1:0] data;
    fill_t                 fill;
    avail_t                avail;
    off_t                  off;
    logic                  cons_ok;
    logic [OFF_W:0]        end_pos;
    logic                  line_done;
    slot_t                 tgt_slot;
    logic                  slot_free;

    assign off       = rd_ptr_q[OFF_W-1:0];
    assign cons_ok   = cons_valid_i && !flush_i && (cons_cnt_i != '0)
                       && (avail_t'(cons_cnt_i) <= avail);
    assign end_pos   = {1'b0, off} + (OFF_W+1)'(cons_cnt_i);
    assign line_done = cons_ok && end_pos[OFF_W];
    assign slot_free = !(&vld);
    assign tgt_slot  = vld[hd_q] ? hd_q + 1'b1 : hd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr_q <= RESET_ADDR;
            hd_q     <= '0;
        end else if (flush_i) begin
            rd_ptr_q <= flush_addr_i;
        end else if (cons_ok) begin
            rd_ptr_q <= rd_ptr_q + ADDR_W'(cons_cnt_i);
            if (line_done) begin
                hd_q <= hd_q + 1'b1;
            end
        end
    end

    pfb_fetch_ctl #(.RESET_ADDR(RESET_ADDR)) u_fetch (
        .clk             (clk),
        .rst             (rst),
        .flush_i         (flush_i),
        .flush_addr_i    (flush_addr_i),
        .slot_free_i     (slot_free),
        .tgt_slot_i      (tgt_slot),
        .mem_req_o       (mem_req_o),
        .mem_req_addr_o  (mem_req_addr_o),
        .mem_req_epoch_o (mem_req_epoch_o),
        .mem_gnt_i       (mem_gnt_i),
        .mem_rsp_valid_i (mem_rsp_valid_i),
        .mem_rsp_epoch_i (mem_rsp_epoch_i),
        .mem_rsp_data_i  (mem_rsp_data_i),
        .fill_o          (fill)
    );

    pfb_line_store u_store (
        .clk         (clk),
        .rst         (rst),
        .flush_i     (flush_i),
        .fill_i      (fill),
        .drop_i      (line_done),
        .drop_slot_i (hd_q),
        .vld_o       (vld),
        .data_o      (data)
    );

    pfb_window u_win (
        .vld_i       (vld),
        .data_i      (data),
        .hd_i        (hd_q),
        .off_i       (off),
        .avail_o     (avail),
        .win_bytes_o (win_bytes_o),
        .win_cnt_o   (win_cnt_o)
    );

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (win_cnt_o == '0)); // R8

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        cons_ok |=> (rd_ptr_q == $past(rd_ptr_q) + ADDR_W'($past(cons_cnt_i)))); // R5

    AST_IGNORED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cons_valid_i && !flush_i && !cons_ok) |=> ($stable(rd_ptr_q) && $stable(hd_q))); // R6

    AST_FULL_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (vld == '1) |-> !mem_req_o); // R11

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        avail_t'(win_cnt_o) <= avail); // R3

endmodule

// File: tb/pfb_prefetch_buf_bench.sv
module pfb_prefetch_buf_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         flush_i = 1'b0;
    logic [31:0]  flush_addr_i = '0;
    logic         cons_valid_i = 1'b0;
    logic [3:0]   cons_cnt_i = '0;
    logic [23:0]  win_bytes_o;
    logic [1:0]   win_cnt_o;
    logic         mem_req_o;
    logic [31:0]  mem_req_addr_o;
    logic [1:0]   mem_req_epoch_o;
    logic         mem_gnt_i = 1'b0;
    logic         mem_rsp_valid_i = 1'b0;
    logic [1:0]   mem_rsp_epoch_i = '0;
    logic [127:0] mem_rsp_data_i = '0;

    always #10 clk = ~clk;

    pfb_prefetch_buf u_pfb_prefetch_buf (
        .clk(clk), .rst(rst), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
        .cons_valid_i(cons_valid_i), .cons_cnt_i(cons_cnt_i),
        .win_bytes_o(win_bytes_o), .win_cnt_o(win_cnt_o),
        .mem_req_o(mem_req_o), .mem_req_addr_o(mem_req_addr_o),
        .mem_req_epoch_o(mem_req_epoch_o), .mem_gnt_i(mem_gnt_i),
        .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_epoch_i(mem_rsp_epoch_i),
        .mem_rsp_data_i(mem_rsp_data_i)
    );

    typedef struct { logic [31:0] addr; int ep; int due; } mreq_t;
    mreq_t mq[$];

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int posedges = 0;
    string ctx = "R1";
    bit gnt = 1'b1;

    logic [31:0] m_ptr;
    logic [31:0] m_next;
    int  m_lines;
    bit  m_pend;
    int  m_ep;

    function automatic logic [7:0] membyte(logic [31:0] a);
        logic [31:0] h;
        h = a * 32'd2654435761;
        return h[23:16] ^ a[7:0];
    endfunction

    function automatic int m_avail();
        if (m_lines == 0) return 0;
        return 16 * m_lines - int'(m_ptr[3:0]);
    endfunction

    task automatic chk(string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", ctx, what, act, exp);
        end
    endtask

    task automatic step(bit fl, logic [31:0] fa, bit cv, int cnt);
        int  ex_cnt;
        int  av;
        bit  ex_req;
        bit  fire;
        bit  rv;
        int  rep;
        av     = m_avail();
        ex_cnt = (av < 3) ? av : 3;
        ex_req = !m_pend && (m_lines < 2);
        chk("win_cnt", win_cnt_o, ex_cnt);
        for (int k = 0; k < ex_cnt; k++)
            chk($sformatf("win_byte%0d", k), win_bytes_o[k*8 +: 8], membyte(m_ptr + 32'(k)));
        chk("mem_req", mem_req_o, ex_req);
        if (ex_req && mem_req_o) begin
            chk("req_addr", mem_req_addr_o, m_next);
            chk("req_epoch", mem_req_epoch_o, m_ep);
        end
        flush_i      = fl;
        flush_addr_i = fa;
        cons_valid_i = cv;
        cons_cnt_i   = 4'(cnt);
        mem_gnt_i    = gnt;
        rv  = 1'b0;
        rep = 0;
        if (mq.size() > 0 && mq[0].due <= cyc) begin
            rv  = 1'b1;
            rep = mq[0].ep;
            for (int i = 0; i < 16; i++) mem_rsp_data_i[i*8 +: 8] = membyte(mq[0].addr + 32'(i));
            mem_rsp_epoch_i = 2'(rep);
            void'(mq.pop_front());
        end
        mem_rsp_valid_i = rv;
        fire = ex_req && gnt;
        if (fire) mq.push_back('{addr: m_next, ep: m_ep, due: cyc + 3});
        if (fl) begin
            m_ep    = (m_ep + 1) % 4;
            m_lines = 0;
            m_pend  = 1'b0;
            m_ptr   = fa;
            m_next  = {fa[31:4], 4'h0};
        end else begin
            if (cv && cnt >= 1 && cnt <= av) begin
                if (int'(m_ptr[3:0]) + cnt >= 16) m_lines--;
                m_ptr = m_ptr + 32'(cnt);
            end
            if (rv && rep == m_ep && m_pend) begin
                m_lines++;
                m_pend = 1'b0;
            end
            if (fire) begin
                m_pend = 1'b1;
                m_next = m_next + 32'd16;
            end
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 0);
    endtask

    always @(posedge clk) begin
        posedges++;
        if (posedges > 100000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", posedges);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        m_ptr = '0; m_next = '0; m_lines = 0; m_pend = 1'b0; m_ep = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        ctx = "R1"; idle(1);
        // R2: two sequential aligned line fetches
        ctx = "R2"; idle(9);
        // R11: both lines full, no further request
        ctx = "R11"; idle(4);
        // R3: window contents under assorted consume sizes
        ctx = "R3";
        step(0, '0, 1, 1); step(0, '0, 1, 2); step(0, '0, 1, 3); step(0, '0, 1, 5);
        idle(1);
        // R4: pointer at offset 14 puts the window across both lines
        ctx = "R4"; step(0, '0, 1, 3); idle(2);
        // R6: zero count ignored
        ctx = "R6"; step(0, '0, 1, 0); idle(1);
        // R7: finishing the older line raises a refill request next cycle
        ctx = "R7"; step(0, '0, 1, 2); idle(6);
        // R6: memory stalled, drain until a count exceeds what is buffered
        ctx = "R6"; gnt = 1'b0;
        for (int i = 0; i < 6; i++) step(0, '0, 1, 15);
        step(0, '0, 1, 7); step(0, '0, 1, 9); idle(1);
        gnt = 1'b1; idle(8);
        // R8: flush empties the window and redirects fetching
        ctx = "R8"; step(1, 32'h0000_1237, 0, 0); idle(2);
        // R9: unaligned target, first byte is the target byte
        ctx = "R9"; idle(8); step(0, '0, 1, 4); idle(1);
        // R10: flush while a request is in flight, stale data must be dropped
        ctx = "R10"; step(1, 32'h0000_2000, 0, 0); idle(1);
        step(1, 32'h0000_3005, 0, 0); idle(10);
        // R5: mixed traffic with pseudo-random counts, grants and redirects
        ctx = "R5"; lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            gnt = lf[0] | lf[5];
            if (lf[11:6] == 6'h15)
                step(1, {16'h0, lf}, 0, 0);
            else
                step(0, '0, lf[1] | lf[2], int'(lf[15:12]));
        end
        gnt = 1'b1; idle(4);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule